// File: doc/BRIEF.md
# Two-Level Carry Lookahead Adder

This block adds two unsigned 16-bit operands and a carry-in in pure combinational logic. The operands are split into four 4-bit slices. Each slice forms a generate and a propagate term for every bit. It resolves the carries inside the slice with flattened lookahead equations, so every internal carry depends only on the slice inputs and the slice carry-in. Each slice also exports a group propagate and a group generate.

A second-level lookahead unit, built from the same equations, takes the four group pairs and the block carry-in. It produces the carries into bits 4, 8 and 12 and the final carry-out, so no carry ripples from one slice to the next. The same unit also forms an overall propagate and generate for the full 16 bits. A wider adder can use these to cascade a further lookahead level. A signed-overflow flag is provided for callers that read the operands as two's complement.

The block has no state, so there are no states or transitions. The result is a function of the present inputs only.

Top module: `cla16_adder`

## Requirements
- R1: `sum_o` equals (`a_i` + `b_i` + `cin_i`) modulo 65536, with all three read as unsigned values.
- R2: `cout_o` equals bit 16 of the unsigned sum `a_i` + `b_i` + `cin_i`.
- R3: Within each 4-bit slice, the carry into bit k is the flattened lookahead of the bit terms g = a AND b and p = a XOR b below k and the slice carry-in. It equals what a bit-by-bit ripple of those terms would give, and sum bit k is p XOR that carry.
- R4: A slice group propagate is the AND of its four bit propagates. Its group generate is g3 + p3g2 + p3p2g1 + p3p2p1g0. When group generate is 1 the slice carry-out is 1; when group propagate is 1 the slice carry-out equals the slice carry-in.
- R5: The second-level unit drives the carries into bits 4, 8 and 12 and the carry-out from the four group pairs and `cin_i` alone. A carry that enters a slice whose every bit propagates reaches the next slice in the same evaluation.
- R6: `grp_p_o` is 1 exactly when every bit of `a_i` XOR `b_i` is 1.
- R7: `grp_g_o` is 1 exactly when `a_i` + `b_i` with no carry-in exceeds 65535.
- R8: `ovf_o` is the carry into bit 15 XOR the carry out of bit 15. This is 1 exactly when `a_i` and `b_i` have the same bit 15 and `sum_o` bit 15 differs from it.
- R9: The block holds no registers; every output follows its inputs with no clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Sum bits |
| cout_o | output | 1 | Carry out of bit 15 |
| grp_p_o | output | 1 | Overall 16-bit propagate |
| grp_g_o | output | 1 | Overall 16-bit generate |
| ovf_o | output | 1 | Signed overflow flag |

## Verification
Every result is due in the same cycle its inputs are applied, zero clock edges later, because the block is combinational. The driver applies a vector shortly after a rising edge and queues the expected item. The monitor pops the item and compares all five outputs at the following falling edge. By then the inputs have been stable for half a period and no edge has intervened. Vectors include full carry chains across each slice boundary, all-propagate operands with carry-in 0 and 1, and signed overflow in both directions. Random vectors complete the set.

// File: rtl/cla_pkg.sv
package cla_pkg;
    localparam int unsigned SLICE_W_DEF    = 4;
    localparam int unsigned NUM_SLICES_DEF = 4;

    typedef struct packed {
        logic p;
        logic g;
    } pg_t;
endpackage

// File: rtl/cla_lookahead.sv
module cla_lookahead #(
    parameter int unsigned N = 4
) (
    input  logic [N-1:0] p_i,
    input  logic [N-1:0] g_i,
    input  logic         c0_i,
    output logic [N:0]   c_o,
    output logic         grp_p_o,
    output logic         grp_g_o
);
    // Flattened carries: carry k is the OR of every generate below k gated by
    // the propagates between it and k, plus c0 gated by all lower propagates.
    always_comb begin
        for (int k = 0; k <= N; k++) begin
            logic acc;
            logic term;
            term = c0_i;
            for (int j = 0; j < k; j++) term = term & p_i[j];
            acc = term;
            for (int j = 0; j < k; j++) begin
                term = g_i[j];
                for (int m = j + 1; m < k; m++) term = term & p_i[m];
                acc = acc | term;
            end
            c_o[k] = acc;
        end
    end

    always_comb begin
        logic gg;
        logic t;
        grp_p_o = &p_i;
        gg = 1'b0;
        for (int j = 0; j < N; j++) begin
            t = g_i[j];
            for (int m = j + 1; m < N; m++) t = t & p_i[m];
            gg = gg | t;
        end
        grp_g_o = gg;
    end

    // R3 / R5: the flattened carries agree with a ripple of the same terms
    always_comb begin
        logic rc;
        rc = c0_i;
        for (int k = 0; k < N; k++) begin
            rc = g_i[k] | (p_i[k] & rc);
            assert_flat_eq_ripple_R3: assert (c_o[k+1] == rc)
                else $error("lookahead carry %0d mismatch", k + 1);
        end
    end
endmodule

// File: rtl/cla_slice.sv
module cla_slice
    import cla_pkg::*;
#(
    parameter int unsigned W = SLICE_W_DEF
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         c_msb_o,
    output pg_t          grp_o
);
    logic [W-1:0] bit_p;
    logic [W-1:0] bit_g;
    logic [W:0]   carry;

    assign bit_p = a_i ^ b_i;
    assign bit_g = a_i & b_i;

    cla_lookahead #(.N(W)) u_la (
        .p_i     (bit_p),
        .g_i     (bit_g),
        .c0_i    (cin_i),
        .c_o     (carry),
        .grp_p_o (grp_o.p),
        .grp_g_o (grp_o.g)
    );

    assign sum_o   = bit_p ^ carry[W-1:0];
    assign cout_o  = carry[W];
    assign c_msb_o = carry[W-1];

    always_comb begin
        assert_slice_add_R3: assert ({cout_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + (W+1)'(cin_i)))
            else $error("slice sum mismatch");
        if (grp_o.g) begin
            assert_group_gen_R4: assert (cout_o == 1'b1)
                else $error("group generate without carry out");
        end
        if (grp_o.p) begin
            assert_group_prop_R4: assert (cout_o == cin_i)
                else $error("group propagate did not pass carry");
        end
    end
endmodule

// File: rtl/cla16_adder.sv
module cla16_adder
    import cla_pkg::*;
#(
    parameter int unsigned SLICE_W    = SLICE_W_DEF,
    parameter int unsigned NUM_SLICES = NUM_SLICES_DEF,
    localparam int unsigned WIDTH     = SLICE_W * NUM_SLICES
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o,
    output logic             grp_p_o,
    output logic             grp_g_o,
    output logic             ovf_o
);
    pg_t  [NUM_SLICES-1:0]  slice_pg;
    logic [NUM_SLICES-1:0]  slice_p;
    logic [NUM_SLICES-1:0]  slice_g;
    logic [NUM_SLICES:0]    level2_c;
    logic [NUM_SLICES-1:0]  slice_cout;
    logic [NUM_SLICES-1:0]  slice_cmsb;

    for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
        cla_slice #(.W(SLICE_W)) u_slice (
            .a_i     (a_i[s*SLICE_W +: SLICE_W]),
            .b_i     (b_i[s*SLICE_W +: SLICE_W]),
            .cin_i   (level2_c[s]),
            .sum_o   (sum_o[s*SLICE_W +: SLICE_W]),
            .cout_o  (slice_cout[s]),
            .c_msb_o (slice_cmsb[s]),
            .grp_o   (slice_pg[s])
        );
        assign slice_p[s] = slice_pg[s].p;
        assign slice_g[s] = slice_pg[s].g;
    end

    cla_lookahead #(.N(NUM_SLICES)) u_level2 (
        .p_i     (slice_p),
        .g_i     (slice_g),
        .c0_i    (cin_i),
        .c_o     (level2_c),
        .grp_p_o (grp_p_o),
        .grp_g_o (grp_g_o)
    );

    assign cout_o = level2_c[NUM_SLICES];
    assign ovf_o  = slice_cmsb[NUM_SLICES-1] ^ level2_c[NUM_SLICES];

    always_comb begin
        for (int s = 0; s < NUM_SLICES; s++) begin
            assert_level2_carry_R5: assert (slice_cout[s] == level2_c[s+1])
                else $error("slice %0d carry disagrees with second level", s);
        end
        assert_total_R1: assert ({cout_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + (WIDTH+1)'(cin_i)))
            else $error("adder total mismatch");
        assert_signed_ovf_R8: assert (ovf_o == ((a_i[WIDTH-1] == b_i[WIDTH-1]) && (sum_o[WIDTH-1] != a_i[WIDTH-1])))
            else $error("overflow flag mismatch");
    end
endmodule

// File: tb/sim_cla16_adder.sv
module sim_cla16_adder;
    typedef struct {
        logic [15:0] sum;
        logic        cout;
        logic        p;
        logic        g;
        logic        ovf;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] a = '0;
    logic [15:0] b = '0;
    logic        cin = 1'b0;
    logic [15:0] sum;
    logic        cout, gp, gg, ovf;
    int          n_checks = 0;
    int          n_fail = 0;
    bit          done = 1'b0;
    exp_t        sb[$];

    always #10 clk = ~clk;

    cla16_adder u0 (
        .a_i(a), .b_i(b), .cin_i(cin),
        .sum_o(sum), .cout_o(cout), .grp_p_o(gp), .grp_g_o(gg), .ovf_o(ovf)
    );

    task automatic check(input string req, input logic [16:0] act, input logic [16:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [15:0] x, input logic [15:0] y, input logic c, input string tag);
        exp_t e;
        logic [16:0] tot;
        @(posedge clk);
        #1;
        a = x; b = y; cin = c;
        tot = {1'b0, x} + {1'b0, y} + 17'(c);
        e.sum  = tot[15:0];
        e.cout = tot[16];
        e.p    = &(x ^ y);
        e.g    = (({1'b0, x} + {1'b0, y}) > 17'd65535);
        e.ovf  = (x[15] == y[15]) && (tot[15] != x[15]);
        e.tag  = tag;
        sb.push_back(e);
    endtask

    // monitor: results are due in the same cycle, sampled at the falling edge
    always @(negedge clk) begin
        if (!rst && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check({"R1 sum ", e.tag}, {1'b0, sum}, {1'b0, e.sum});
            check({"R2 cout ", e.tag}, {16'b0, cout}, {16'b0, e.cout});
            check({"R6 grp_p ", e.tag}, {16'b0, gp}, {16'b0, e.p});
            check({"R7 grp_g ", e.tag}, {16'b0, gg}, {16'b0, e.g});
            check({"R8 ovf ", e.tag}, {16'b0, ovf}, {16'b0, e.ovf});
        end
    end

    initial begin
        #5000000;
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        repeat (2) @(posedge clk);
        #1;
        // R9: zero inputs give zero outputs with no clock edge involved
        check("R9 reset-state sum", {cout, sum}, 17'h0);
        check("R9 reset-state flags", {14'b0, gp, gg, ovf}, 17'h0);
        a = 16'h1234; b = 16'h4321; cin = 1'b1;
        #2;
        check("R9 comb response", {cout, sum}, 17'h05556);
        rst = 1'b0;
        drive(16'hFFFF, 16'h0001, 1'b0, "R5 full chain cin0");
        drive(16'hFFFF, 16'h0001, 1'b1, "R5 full chain cin1");
        drive(16'hFFFF, 16'h0000, 1'b1, "R6 all propagate cin1");
        drive(16'hAAAA, 16'h5555, 1'b0, "R6 all propagate cin0");
        drive(16'h000F, 16'h0001, 1'b0, "R3 slice0 carry to bit4");
        drive(16'h00F0, 16'h0010, 1'b0, "R4 slice1 generate to bit8");
        drive(16'h0F00, 16'h0100, 1'b0, "R4 slice2 to bit12");
        drive(16'h0FFF, 16'h0000, 1'b1, "R4 propagate through three slices");
        drive(16'h8000, 16'h8000, 1'b0, "R7 top generate");
        drive(16'h7FFF, 16'h0001, 1'b0, "R8 positive overflow");
        drive(16'h8000, 16'hFFFF, 1'b0, "R8 negative overflow");
        drive(16'hFFFF, 16'hFFFF, 1'b1, "R2 max operands");
        drive(16'h0000, 16'h0000, 1'b0, "R1 zero");
        drive(16'h5A5A, 16'h0F0F, 1'b1, "R3 mixed");
        seed = 32'h1ACE_0001;
        for (int i = 0; i < 400; i++) begin
            logic [15:0] x, y;
            seed = seed * 32'd1664525 + 32'd1013904223;
            x = seed[31:16];
            seed = seed * 32'd1664525 + 32'd1013904223;
            y = seed[31:16];
            drive(x, y, seed[3], "R1 random");
        end
        @(posedge clk);
        @(negedge clk);
        #1;
        check("R1 scoreboard drained", {16'b0, sb.size() == 0}, 17'h1);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule